// File: doc/BRIEF.md
# Seconds and Reference-Cycle Timebase

This block keeps two free-running, read-only counters that restart on every cold reset. The first holds the number of whole seconds since that reset. The second approximates a count of 25 MHz reference cycles. It advances by sixteen on every 640 ns tick, so it moves in coarse steps and its four low bits always read as zero. It returns to zero once per second, at the moment the seconds counter steps up.

The 640 ns tick is derived inside the block by a prescaler on the system clock, with a default ratio of 32 for a 50 MHz clock. Software reads both counters as 32-bit words over a simple register port, and read data returns one cycle after the request. Writes to either counter are accepted on the port and change nothing.

Top module: `secs_timebase`

## Requirements
- R1: On each tick the cycle counter (read at byte offset 0x6C) increases by CYCLE_STEP (16 by default), unless it wraps.
- R2: Bits [3:0] of the cycle counter always read as zero.
- R3: When a tick arrives with the cycle counter at WRAP_VALUE - CYCLE_STEP (24,999,984 by default), the counter becomes 0. It never holds WRAP_VALUE or more.
- R4: The seconds counter (read at byte offset 0x68) increases by one on exactly the tick on which the cycle counter wraps, and at no other time.
- R5: A tick occurs once every PRESCALE_DIV system clocks (32 by default). The first tick falls on the PRESCALE_DIV-th rising edge after reset is released.
- R6: A cold reset (rst high at a rising edge) clears both counters, the prescaler and the read-valid output.
- R7: A write access (regEn=1, regWe=1) to either counter address changes neither counter and produces no read-valid pulse.
- R8: A read access (regEn=1, regWe=0) raises regRvalid for one cycle on the next clock, with regRdata holding the counter value from before that edge. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high cold reset |
| regEn | input | 1 | Register access request for this cycle |
| regWe | input | 1 | 1 = write access, 0 = read access |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | 32 | Write data (discarded) |
| regRdata | output | 32 | Read data, valid with regRvalid |
| regRvalid | output | 1 | One-cycle pulse on the cycle after a read |

## Verification
The checks assume that rst is held high at the first clock edge, so every counter starts from a known zero. They also assume that WRAP_VALUE is an exact multiple of CYCLE_STEP, so the wrap value is reached exactly. The bench instantiates the block with a prescaler of 4 and a wrap of 160, which gives ten ticks per second. Every wrap and step of the seconds counter then falls inside a short run. The bench reads on back-to-back cycles across several seconds, issues writes, and applies a reset in the middle of the run. It computes every expected value from its own count of clock edges since reset.

// File: rtl/secs_timebase_pkg.sv
package secs_timebase_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;    // 640 ns interval elapsed
    logic wrap;    // tick that closes a second
    logic rdEn;    // capture read data this cycle
    logic selSec;  // read targets seconds counter
    logic selCyc;  // read targets cycle counter
  } tbStrobes_t;

endpackage

// File: rtl/secs_timebase_ctrl.sv
module secs_timebase_ctrl
  import secs_timebase_pkg::*;
#(
  parameter int PRESCALE_DIV = 32,
  parameter int ADDR_W       = 12,
  parameter int SEC_OFFSET   = 'h68,
  parameter int CYC_OFFSET   = 'h6C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              atLast,
  output tbStrobes_t        strobes
);

  localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(SEC_OFFSET);
  localparam logic [ADDR_W-1:0] CYC_ADDR = ADDR_W'(CYC_OFFSET);

  logic tick;

  generate
    if (PRESCALE_DIV <= 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          preCnt <= '0;
        end else if (preCnt == PRE_LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = (preCnt == PRE_LAST);
    end
  endgenerate

  logic rdReq;
  assign rdReq = regEn & ~regWe;

  always_comb begin
    strobes        = '0;
    strobes.tick   = tick;
    strobes.wrap   = tick & atLast;
    strobes.rdEn   = rdReq;
    strobes.selSec = rdReq & (regAddr == SEC_ADDR);
    strobes.selCyc = rdReq & (regAddr == CYC_ADDR);
  end

endmodule

// File: rtl/secs_timebase_dp.sv
module secs_timebase_dp
  import secs_timebase_pkg::*;
#(
  parameter int CYCLE_STEP = 16,
  parameter int WRAP_VALUE = 25_000_000,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tbStrobes_t       strobes,
  output logic             atLast,
  output logic [CNT_W-1:0] cycleCount,
  output logic [CNT_W-1:0] secCount,
  output logic [CNT_W-1:0] regRdata,
  output logic             regRvalid
);

  localparam logic [CNT_W-1:0] STEP_V   = CNT_W'(CYCLE_STEP);
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(WRAP_VALUE - CYCLE_STEP);

  assign atLast = (cycleCount == LAST_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCount <= '0;
      secCount   <= '0;
    end else if (strobes.wrap) begin
      cycleCount <= '0;
      secCount   <= secCount + 1'b1;
    end else if (strobes.tick) begin
      cycleCount <= cycleCount + STEP_V;
    end
  end

  logic [CNT_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    if (strobes.selSec) begin
      rdMux = secCount;
    end else if (strobes.selCyc) begin
      rdMux = cycleCount;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdata  <= '0;
      regRvalid <= 1'b0;
    end else begin
      regRvalid <= strobes.rdEn;
      if (strobes.rdEn) begin
        regRdata <= rdMux;
      end
    end
  end

endmodule

// File: rtl/secs_timebase.sv
module secs_timebase
  import secs_timebase_pkg::*;
#(
  parameter int PRESCALE_DIV = 32,
  parameter int CYCLE_STEP   = 16,
  parameter int WRAP_VALUE   = 25_000_000,
  parameter int ADDR_W       = 12,
  parameter int SEC_OFFSET   = 'h68,
  parameter int CYC_OFFSET   = 'h6C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regRvalid
);

  localparam int CNT_W = 32;

  tbStrobes_t       strobes;
  logic             atLast;
  logic [CNT_W-1:0] cycleCount;
  logic [CNT_W-1:0] secCount;

  // Write data is discarded: both counters are read-only
  logic unusedWdata;
  assign unusedWdata = ^regWdata;

  secs_timebase_ctrl #(
    .PRESCALE_DIV(PRESCALE_DIV),
    .ADDR_W      (ADDR_W),
    .SEC_OFFSET  (SEC_OFFSET),
    .CYC_OFFSET  (CYC_OFFSET)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .regEn  (regEn),
    .regWe  (regWe),
    .regAddr(regAddr),
    .atLast (atLast),
    .strobes(strobes)
  );

  secs_timebase_dp #(
    .CYCLE_STEP(CYCLE_STEP),
    .WRAP_VALUE(WRAP_VALUE),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .atLast    (atLast),
    .cycleCount(cycleCount),
    .secCount  (secCount),
    .regRdata  (regRdata),
    .regRvalid (regRvalid)
  );

endmodule

// File: rtl/secs_timebase_chk.sv
module secs_timebase_chk
  import secs_timebase_pkg::*;
#(
  parameter int PRESCALE_DIV = 32,
  parameter int CYCLE_STEP   = 16,
  parameter int WRAP_VALUE   = 25_000_000,
  parameter int CNT_W        = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             regEn,
  input logic             regWe,
  input logic             regRvalid,
  input tbStrobes_t       strobes,
  input logic [CNT_W-1:0] cycleCount,
  input logic [CNT_W-1:0] secCount
);

  localparam int GAP_W = $clog2(PRESCALE_DIV + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PRESCALE_DIV - 1);

  // Clocks since the last tick, measured independently of the prescaler
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst || strobes.tick) begin
      gap <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && !strobes.wrap) |=>
      (cycleCount == $past(cycleCount) + CNT_W'(CYCLE_STEP)));

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cycleCount[3:0] == 4'd0);

  assert_below_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    cycleCount < CNT_W'(WRAP_VALUE));

  assert_wrap_sec_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.wrap |=> (cycleCount == '0 && secCount == $past(secCount) + 1'b1));

  assert_sec_only_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrap |=> (secCount == $past(secCount)));

  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.tick |-> (gap == GAP_LAST));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (cycleCount == '0 && secCount == '0 && !regRvalid));

  assert_write_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (regEn && regWe) |=> !regRvalid);

  assert_read_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (regEn && !regWe) |=> regRvalid);

endmodule

bind secs_timebase secs_timebase_chk #(
  .PRESCALE_DIV(PRESCALE_DIV),
  .CYCLE_STEP  (CYCLE_STEP),
  .WRAP_VALUE  (WRAP_VALUE),
  .CNT_W       (32)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regEn     (regEn),
  .regWe     (regWe),
  .regRvalid (regRvalid),
  .strobes   (strobes),
  .cycleCount(cycleCount),
  .secCount  (secCount)
);

// File: tb/test_secs_timebase.sv
`timescale 1ns/1ps
module test_secs_timebase;

  localparam int DIV  = 4;
  localparam int STEP = 16;
  localparam int WRAP = 160;
  localparam int TPS  = WRAP / STEP;
  localparam logic [11:0] SEC_A = 12'h068;
  localparam logic [11:0] CYC_A = 12'h06C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regEn = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRvalid;

  always #2 clk = ~clk;

  secs_timebase #(
    .PRESCALE_DIV(DIV),
    .CYCLE_STEP  (STEP),
    .WRAP_VALUE  (WRAP)
  ) i_secs_timebase (
    .clk      (clk),
    .rst      (rst),
    .regEn    (regEn),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .regRvalid(regRvalid)
  );

  int total = 0;
  int bad   = 0;
  int edgeCnt = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  // Rising edges since reset release
  always @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  // Driver: issue a read at a falling edge and predict its result
  task automatic doRead(input logic [11:0] a, input string tag);
    int t;
    logic [31:0] e;
    t = edgeCnt / DIV;
    if (a == SEC_A)      e = 32'(t / TPS);
    else if (a == CYC_A) e = 32'((t % TPS) * STEP);
    else                 e = 32'd0;
    regEn = 1'b1; regWe = 1'b0; regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    regEn = 1'b0;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    regEn = 1'b1; regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  // Monitor: compare each returned word with the queued prediction
  always @(negedge clk) begin
    if (!rst && regRvalid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R7 R8 unexpected read-valid: actual=%h expected=no pulse", regRdata);
      end else begin
        logic [31:0] e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        if (regRdata !== e) begin
          bad++;
          $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tg, edgeCnt, regRdata, e);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (regRvalid !== 1'b0 || regRdata !== 32'd0) begin
      bad++;
      $display("FAIL R6 outputs in reset: actual=%b/%h expected=0/0", regRvalid, regRdata);
    end
    rst = 1'b0;

    // Reset state, then tick timing and stepping
    doRead(SEC_A, "R6 seconds after reset");
    doRead(CYC_A, "R6 R5 cycle after reset");
    for (int i = 0; i < 60; i++) doRead(CYC_A, "R1 R2 R3 R5 cycle sweep");

    // Alternate reads across several wraps
    for (int i = 0; i < 120; i++) begin
      if (i % 2 == 0) doRead(SEC_A, "R4 seconds sweep");
      else            doRead(CYC_A, "R1 R3 cycle sweep");
    end

    // Writes are ignored
    doWrite(CYC_A, 32'hFFFF_FFF0);
    doRead(CYC_A, "R7 cycle after write");
    doWrite(SEC_A, 32'h0000_1234);
    doRead(SEC_A, "R7 seconds after write");
    doWrite(CYC_A, 32'd0);
    doRead(CYC_A, "R7 cycle after zero write");

    // Unmapped offsets read zero
    doRead(12'h070, "R8 unmapped offset");
    doRead(12'h06D, "R8 misaligned offset");
    doRead(12'h000, "R8 offset zero");

    // Cold reset in the middle of a second
    repeat (13) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    doRead(CYC_A, "R6 cycle after cold reset");
    doRead(SEC_A, "R6 seconds after cold reset");

    // Longer run to many seconds
    for (int i = 0; i < 400; i++) begin
      if (i % 3 == 0) doRead(SEC_A, "R4 long seconds");
      else            doRead(CYC_A, "R1 R2 R3 long cycle");
    end

    repeat (4) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R8 missing read-valid: actual=%0d pending expected=0", expQ.size());
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule